// File: doc/BRIEF.md
# Sequencer Opcode Word Validator

This block sits between the instruction fetch of a bus-controller sequencer and its execution stage. It inspects each 16-bit opcode word before the word is used. Three checks are made: odd parity over all sixteen bits, a fixed five-bit signature in the middle of the word, and a lookup of the opcode field in a parameter mask of defined operations. The block presents the opcode and condition fields with a pass flag one clock after the fetch strobe.

Any failed check stops the sequencer. A small state machine has two states. `ST_RUN` accepts words. `ST_HALT` is reached on the transition *fault* (a strobed word fails any check) and is left only by reset. In `ST_HALT` incoming strobes are ignored. A failing word can raise two interrupt requests, each gated by its own enable sampled with the word. The trap request covers a bad signature or an undefined opcode. The parity request covers a parity failure.

The word layout is: bit 15 parity, bits 14..10 opcode, bits 9..5 signature, bits 4..0 condition code.

Top module: `opword_checker`

## Requirements
- R1: After reset, `res_vld`, `word_ok`, `trap_irq`, `par_irq` and `halt` are all 0.
- R2: In `ST_RUN`, a word strobed on `word_vld` at one rising edge produces `res_vld`=1 for exactly one cycle after that edge. At the same time, `op_code` shows word bits 14..10 and `cond_code` shows word bits 4..0.
- R3: A word passes the parity check only when the count of ones over all 16 bits, parity bit 15 included, is odd.
- R4: A word passes the signature check only when bits 9..5 equal binary 01010.
- R5: A word passes the opcode check only when bit `op_code` of `OP_MASK` is set. The default mask 32'h00FF03FF defines opcodes 0–9 and 16–23. `word_ok` is 1 only when all three checks pass.
- R6: A failing word moves the block to `ST_HALT`. `halt` rises in the same cycle as that word's `res_vld` and stays 1 until reset, whatever the enables are.
- R7: `trap_irq` pulses for one cycle with the result when the signature check or the opcode check fails and `trap_en` was 1 with the word. Otherwise it stays 0.
- R8: `par_irq` pulses for one cycle with the result when the parity check fails and `par_en` was 1 with the word. Otherwise it stays 0. A parity failure halts even with `par_en`=0.
- R9: In `ST_HALT`, strobed words are ignored: `res_vld`, `trap_irq` and `par_irq` stay 0.
- R10: A word that fails parity and also fails the signature or opcode check raises `trap_irq` and `par_irq` in the same cycle when both are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_vld | input | 1 | Fetched word strobe |
| word | input | 16 | Fetched opcode word |
| trap_en | input | 1 | Enable for the trap interrupt request |
| par_en | input | 1 | Enable for the parity interrupt request |
| res_vld | output | 1 | Check result valid, one cycle after the strobe |
| word_ok | output | 1 | All three checks passed |
| op_code | output | 5 | Opcode field of the checked word |
| cond_code | output | 5 | Condition code field of the checked word |
| trap_irq | output | 1 | Trap interrupt request pulse |
| par_irq | output | 1 | Parity interrupt request pulse |
| halt | output | 1 | Sticky stop to the sequencer |

## Verification
The trap and parity requests are separate paths, and they can fire in the same result cycle. The bench provokes this with words that carry even parity together with a wrong signature, or with an undefined opcode. It expects both pulses and `halt` together in that one cycle. It also pairs each fault with its enable cleared, so that one request fires while the other stays silent. The scoreboard compares every field of every result against a model built from the bit layout alone.

// File: rtl/opchk_pkg.sv
package opchk_pkg;

    localparam int WORD_W = 16;
    localparam int OP_W   = 5;
    localparam int SIG_W  = 5;
    localparam int CC_W   = 5;
    localparam int NUM_OPS = 1 << OP_W;

    localparam logic [SIG_W-1:0] SIG_VALUE = 5'b01010;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } chk_state_e;

    typedef struct packed {
        logic par_bad;
        logic sig_bad;
        logic op_bad;
    } fault_t;

endpackage

// File: rtl/opchk_parity.sv
module opchk_parity #(
    parameter int W = 16
) (
    input  logic [W-1:0] word,
    output logic         odd_ok
);
    // Running XOR chain across the word; odd ones count leaves a 1.
    logic [W-1:0] chain;

    assign chain[0] = word[0];
    for (genvar i = 1; i < W; i++) begin : g_chain
        assign chain[i] = chain[i-1] ^ word[i];
    end

    assign odd_ok = chain[W-1];
endmodule

// File: rtl/opchk_field_decode.sv
module opchk_field_decode
    import opchk_pkg::*;
#(
    parameter logic [NUM_OPS-1:0] OP_MASK = 32'h00FF_03FF
) (
    input  logic [WORD_W-1:0] word,
    output logic [OP_W-1:0]   op_field,
    output logic [CC_W-1:0]   cc_field,
    output logic              sig_ok,
    output logic              op_defined
);
    localparam int CC_LSB  = 0;
    localparam int SIG_LSB = CC_LSB + CC_W;
    localparam int OP_LSB  = SIG_LSB + SIG_W;

    logic [SIG_W-1:0]   sig_field;
    logic [NUM_OPS-1:0] hit;

    assign cc_field  = word[CC_LSB  +: CC_W];
    assign sig_field = word[SIG_LSB +: SIG_W];
    assign op_field  = word[OP_LSB  +: OP_W];

    assign sig_ok = (sig_field == SIG_VALUE);

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_lookup
        if (OP_MASK[i]) begin : g_def
            assign hit[i] = (op_field == OP_W'(i));
        end else begin : g_undef
            assign hit[i] = 1'b0;
        end
    end

    assign op_defined = |hit;
endmodule

// File: rtl/opchk_ctrl.sv
module opchk_ctrl
    import opchk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            word_vld,
    input  logic            trap_en,
    input  logic            par_en,
    input  fault_t          fault,
    input  logic [OP_W-1:0] op_field,
    input  logic [CC_W-1:0] cc_field,
    output logic            res_vld,
    output logic            word_ok,
    output logic [OP_W-1:0] op_code,
    output logic [CC_W-1:0] cond_code,
    output logic            trap_irq,
    output logic            par_irq,
    output logic            halt
);
    chk_state_e state_q, state_d;
    logic       accept;
    logic       any_fault;

    assign accept    = word_vld && (state_q == ST_RUN);
    assign any_fault = fault.par_bad | fault.sig_bad | fault.op_bad;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (accept && any_fault) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld   <= 1'b0;
            word_ok   <= 1'b0;
            op_code   <= '0;
            cond_code <= '0;
            trap_irq  <= 1'b0;
            par_irq   <= 1'b0;
        end else begin
            res_vld  <= accept;
            word_ok  <= accept && !any_fault;
            trap_irq <= accept && trap_en && (fault.sig_bad | fault.op_bad);
            par_irq  <= accept && par_en && fault.par_bad;
            if (accept) begin
                op_code   <= op_field;
                cond_code <= cc_field;
            end
        end
    end

    assign halt = (state_q == ST_HALT);

    // R6
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    // R6
    fail_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !word_ok) |-> halt);

    // R2
    res_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(word_vld));

    // R9
    halted_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && $past(halt)) |-> (!res_vld && !trap_irq && !par_irq));

    // R7
    trap_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_irq |-> (res_vld && !word_ok && $past(trap_en)));

    // R8
    par_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_irq |-> (res_vld && halt && $past(par_en)));

    // R2
    pass_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_ok |-> (res_vld && !halt));
endmodule

// File: rtl/opword_checker.sv
module opword_checker
    import opchk_pkg::*;
#(
    parameter logic [NUM_OPS-1:0] OP_MASK = 32'h00FF_03FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_vld,
    input  logic [15:0] word,
    input  logic        trap_en,
    input  logic        par_en,
    output logic        res_vld,
    output logic        word_ok,
    output logic [4:0]  op_code,
    output logic [4:0]  cond_code,
    output logic        trap_irq,
    output logic        par_irq,
    output logic        halt
);
    logic            odd_ok;
    logic            sig_ok;
    logic            op_defined;
    logic [OP_W-1:0] op_field;
    logic [CC_W-1:0] cc_field;
    fault_t          fault;

    opchk_parity #(.W(WORD_W)) u_parity (
        .word   (word),
        .odd_ok (odd_ok)
    );

    opchk_field_decode #(.OP_MASK(OP_MASK)) u_decode (
        .word       (word),
        .op_field   (op_field),
        .cc_field   (cc_field),
        .sig_ok     (sig_ok),
        .op_defined (op_defined)
    );

    assign fault.par_bad = !odd_ok;
    assign fault.sig_bad = !sig_ok;
    assign fault.op_bad  = !op_defined;

    opchk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_vld  (word_vld),
        .trap_en   (trap_en),
        .par_en    (par_en),
        .fault     (fault),
        .op_field  (op_field),
        .cc_field  (cc_field),
        .res_vld   (res_vld),
        .word_ok   (word_ok),
        .op_code   (op_code),
        .cond_code (cond_code),
        .trap_irq  (trap_irq),
        .par_irq   (par_irq),
        .halt      (halt)
    );
endmodule

// File: tb/tb_opword_checker.sv
module tb_opword_checker;

    typedef struct packed {
        logic [4:0] op;
        logic [4:0] cc;
        logic       ok;
        logic       trap;
        logic       par;
    } exp_t;

    localparam logic [31:0] MASK = 32'h00FF_03FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_vld = 1'b0;
    logic [15:0] word = '0;
    logic        trap_en = 1'b0;
    logic        par_en = 1'b0;
    logic        res_vld, word_ok, trap_irq, par_irq, halt;
    logic [4:0]  op_code, cond_code;

    int   nchk = 0;
    int   nfail = 0;
    bit   m_halted = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    opword_checker dut (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
        .trap_en(trap_en), .par_en(par_en), .res_vld(res_vld),
        .word_ok(word_ok), .op_code(op_code), .cond_code(cond_code),
        .trap_irq(trap_irq), .par_irq(par_irq), .halt(halt)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mkw(input logic [4:0] op, input logic [4:0] sig,
                                        input logic [4:0] cc, input bit good_par);
        logic [14:0] low;
        logic        p;
        low = {op, sig, cc};
        p = ~(^low);
        if (!good_par) p = ~p;
        return {p, low};
    endfunction

    // Driver: one strobed word per call, expected item pushed when accepted.
    task automatic send(input logic [15:0] w, input bit ten, input bit pen);
        exp_t e;
        bit par_bad, sig_bad, op_bad;
        @(negedge clk);
        word = w; word_vld = 1'b1; trap_en = ten; par_en = pen;
        par_bad = ~(^w);
        sig_bad = (w[9:5] != 5'b01010);
        op_bad  = !MASK[w[14:10]];
        if (!m_halted) begin
            e.op   = w[14:10];
            e.cc   = w[4:0];
            e.ok   = !(par_bad | sig_bad | op_bad);
            e.trap = ten & (sig_bad | op_bad);
            e.par  = pen & par_bad;
            sb.push_back(e);
            if (!e.ok) m_halted = 1'b1;
        end
        @(negedge clk);
        word_vld = 1'b0; word = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_halted = 1'b0;
        sb.delete();
        rst_n = 1'b1;
        check("R1", "res_vld after reset", res_vld, 0);
        check("R1", "halt after reset", halt, 0);
        check("R1", "trap_irq after reset", trap_irq, 0);
        check("R1", "par_irq after reset", par_irq, 0);
        check("R1", "word_ok after reset", word_ok, 0);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        check("R2", "scoreboard empty", sb.size(), 0);
    endtask

    // Monitor: compare every result against the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (res_vld) begin
                    if (sb.size() == 0) begin
                        check("R9", "unexpected res_vld", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check("R2", "op_code", op_code, e.op);
                        check("R2", "cond_code", cond_code, e.cc);
                        check("R5", "word_ok", word_ok, e.ok);
                        check("R7", "trap_irq", trap_irq, e.trap);
                        check("R8", "par_irq", par_irq, e.par);
                        check("R6", "halt with result", halt, !e.ok);
                    end
                end else begin
                    if (trap_irq) check("R7", "trap_irq without result", 1, 0);
                    if (par_irq)  check("R8", "par_irq without result", 1, 0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        do_reset();

        // R2 R5: defined opcodes at both ends of each range, back to back
        send(mkw(5'd0,  5'b01010, 5'd3,  1), 1, 1);
        send(mkw(5'd9,  5'b01010, 5'd31, 1), 1, 1);
        send(mkw(5'd16, 5'b01010, 5'd0,  1), 1, 1);
        send(mkw(5'd23, 5'b01010, 5'd17, 1), 0, 0);
        drain();
        check("R6", "halt after good words", halt, 0);

        // R5 R7: undefined opcode 10, trap enabled
        send(mkw(5'd10, 5'b01010, 5'd5, 1), 1, 1);
        drain();
        check("R6", "halt latched", halt, 1);
        // R9: words ignored while halted
        send(mkw(5'd1, 5'b01010, 5'd2, 1), 1, 1);
        send(mkw(5'd31, 5'b11111, 5'd2, 0), 1, 1);
        drain();
        check("R6", "halt still set", halt, 1);
        check("R9", "res_vld while halted", res_vld, 0);

        // R4 R7: bad signature, trap disabled -> halt, no request
        do_reset();
        send(mkw(5'd2, 5'b01011, 5'd9, 1), 0, 1);
        drain();
        check("R4", "halt on bad signature", halt, 1);

        // R3 R8: parity only, both enables
        do_reset();
        send(mkw(5'd4, 5'b01010, 5'd6, 0), 1, 1);
        drain();
        check("R3", "halt on parity", halt, 1);

        // R8: parity with par_en=0 still halts
        do_reset();
        send(mkw(5'd5, 5'b01010, 5'd1, 0), 1, 0);
        drain();
        check("R8", "halt with parity irq disabled", halt, 1);

        // R10: parity and signature fail together
        do_reset();
        send(mkw(5'd3, 5'b00000, 5'd12, 0), 1, 1);
        drain();

        // R10: parity and undefined opcode 31 together
        do_reset();
        send(mkw(5'd31, 5'b01010, 5'd8, 0), 1, 1);
        drain();

        // R5: opcode 15 and 24 undefined, trap only
        do_reset();
        send(mkw(5'd15, 5'b01010, 5'd4, 1), 1, 0);
        drain();
        do_reset();
        send(mkw(5'd24, 5'b01010, 5'd4, 1), 1, 1);
        drain();

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule